// File: doc/BRIEF.md
# PDM Capture and Routing Front End

This block makes the PDM bit clock for external microphones by dividing the interface clock. It samples a set of PDM data lines and feeds each receiver two one-bit streams, left and right, for the decimation filters that follow. The data line for a microphone pair carries one microphone on each half of the PDM clock. The receiver takes the sample that follows the rising edge as left and the sample that follows the falling edge as right. Each sample comes with its own single-cycle valid strobe.

Software programs the divider and the per-receiver capture delay as "value minus one". Each receiver can read its own data line or swap to its neighbour, the line whose index differs only in the lowest bit. A halve-rate option keeps the PDM clock running but discards the samples of every second clock period. Configuration is static and changes only while reset is held. The receiver count must be even.

Top module: `pdm_capture_frontend`

## Requirements
- R1: With divider value V, pdm_clk repeats every Ve+1 interface cycles, where Ve = V, or Ve = 1 when V is 0.
- R2: Each pdm_clk period starts with floor((Ve+1)/2) high cycles and is low for the rest. pdm_clk goes high on the first clock edge after reset is released.
- R3: With D = min(sample delay, Ve), a receiver samples its selected line at the (D+1)th interface edge after the edge that raised pdm_clk. It shows that bit on left_bit, with left_vld high, for the single cycle after that edge.
- R4: A receiver samples the right bit at the (D+1)th interface edge after the edge that lowered pdm_clk, even when that edge falls in the next period. It presents the bit on right_bit with right_vld high for the single cycle after that edge.
- R5: Route bit j = 0 makes receiver j read pdm_data_in[j]. Route bit j = 1 makes it read pdm_data_in[j XOR 1].
- R6: With halve_rate set, only samples whose originating pdm_clk edge lies in an even-numbered period are valid. The first period after reset is period 0. pdm_clk itself is unchanged.
- R7: A sample delay larger than Ve behaves exactly as a delay of Ve.
- R8: While reset is high, pdm_clk and all sample bits and valid strobes are 0.
- R9: A valid strobe is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_div | input | 8 | PDM clock divider, divide by value+1 |
| cfg_sample_dly | input | 8*N_RX | Per-receiver capture delay, receiver j in bits [8j+7:8j] |
| cfg_route_swap | input | N_RX | Per-receiver neighbour-line select |
| cfg_halve | input | 1 | Keep only alternate periods' samples |
| pdm_data_in | input | N_RX | PDM data lines |
| pdm_clk_out | output | 1 | Generated PDM clock |
| left_bit | output | N_RX | Left-channel sample per receiver |
| left_vld | output | N_RX | Left-channel valid strobe |
| right_bit | output | N_RX | Right-channel sample per receiver |
| right_vld | output | N_RX | Right-channel valid strobe |

## Verification
pdm_clk is registered. It takes its new level one cycle after the counter position that calls for it, so its first high cycle follows the first edge after reset. A sample bit is captured at an interface edge and is visible, with its strobe, for exactly the one following cycle. A delay of D therefore puts the strobe D+1 cycles after the cycle in which pdm_clk first shows the edge. The bench model steps on every rising edge from the same inputs. The bench compares pdm_clk, every strobe and every valid bit at the next falling edge, the one point where the registered result for that edge is settled.

// File: rtl/pdm_fe_pkg.sv
package pdm_fe_pkg;
    parameter int unsigned DIV_W = 8;
    localparam int unsigned SPAN_W = DIV_W + 1;

    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [SPAN_W-1:0] span_t;

    typedef struct packed {
        logic data;
        logic vld;
    } pdm_sample_t;

    typedef enum logic {
        PERIOD_EVEN = 1'b0,
        PERIOD_ODD  = 1'b1
    } period_par_e;

    // divider value actually used: zero is raised to one
    function automatic div_t eff_div(input div_t v);
        return (v == '0) ? div_t'(1) : v;
    endfunction

    // number of high interface cycles in one PDM period
    function automatic div_t high_len(input div_t ve);
        span_t per;
        per = span_t'(ve) + span_t'(1);
        return div_t'(per >> 1);
    endfunction

    function automatic div_t clamp_dly(input div_t d, input div_t ve);
        return (d > ve) ? ve : d;
    endfunction
endpackage

// File: rtl/pdm_fe_clkgen.sv
module pdm_fe_clkgen
    import pdm_fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  div_t        cfg_div,
    output div_t        ve,
    output div_t        hlen,
    output div_t        pos,
    output period_par_e parity,
    output logic        pdm_clk
);
    div_t cnt_q;
    logic pclk_q;
    period_par_e par_q;

    assign ve   = eff_div(cfg_div);
    assign hlen = high_len(ve);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= ve;
            pclk_q <= 1'b0;
            par_q  <= PERIOD_ODD;
        end else if (cnt_q >= ve) begin
            cnt_q  <= '0;
            pclk_q <= 1'b1;
            par_q  <= (par_q == PERIOD_ODD) ? PERIOD_EVEN : PERIOD_ODD;
        end else begin
            cnt_q  <= cnt_q + div_t'(1);
            pclk_q <= (span_t'(cnt_q) + span_t'(1)) < span_t'(hlen);
        end
    end

    assign pos     = cnt_q;
    assign parity  = par_q;
    assign pdm_clk = pclk_q;
endmodule

// File: rtl/pdm_fe_lane.sv
module pdm_fe_lane
    import pdm_fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  div_t        ve,
    input  div_t        hlen,
    input  div_t        pos,
    input  period_par_e parity,
    input  logic        halve,
    input  div_t        dly,
    input  logic        din,
    output pdm_sample_t left_o,
    output pdm_sample_t right_o
);
    div_t        d_eff;
    span_t       per, rsum, rtgt;
    logic        wrap, hit_l, hit_r, ok_l, ok_r;
    period_par_e r_origin;
    pdm_sample_t left_q, right_q;

    always_comb begin
        d_eff    = clamp_dly(dly, ve);
        per      = span_t'(ve) + span_t'(1);
        rsum     = span_t'(hlen) + span_t'(d_eff);
        wrap     = rsum >= per;
        rtgt     = wrap ? (rsum - per) : rsum;
        // a wrapped right capture stems from the previous period
        r_origin = wrap ? ((parity == PERIOD_ODD) ? PERIOD_EVEN : PERIOD_ODD) : parity;
        ok_l     = !halve || (parity == PERIOD_EVEN);
        ok_r     = !halve || (r_origin == PERIOD_EVEN);
        hit_l    = (pos == d_eff) && ok_l;
        hit_r    = (span_t'(pos) == rtgt) && ok_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            right_q <= '0;
        end else begin
            left_q.vld  <= hit_l;
            right_q.vld <= hit_r;
            if (hit_l) left_q.data  <= din;
            if (hit_r) right_q.data <= din;
        end
    end

    assign left_o  = left_q;
    assign right_o = right_q;
endmodule

// File: rtl/pdm_capture_frontend.sv
module pdm_capture_frontend
    import pdm_fe_pkg::*;
#(
    parameter int unsigned N_RX = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DIV_W-1:0]      cfg_clk_div,
    input  logic [N_RX*DIV_W-1:0] cfg_sample_dly,
    input  logic [N_RX-1:0]       cfg_route_swap,
    input  logic                  cfg_halve,
    input  logic [N_RX-1:0]       pdm_data_in,
    output logic                  pdm_clk_out,
    output logic [N_RX-1:0]       left_bit,
    output logic [N_RX-1:0]       left_vld,
    output logic [N_RX-1:0]       right_bit,
    output logic [N_RX-1:0]       right_vld
);
    div_t        ve, hlen, pos;
    period_par_e parity;

    pdm_fe_clkgen u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .cfg_div (cfg_clk_div),
        .ve      (ve),
        .hlen    (hlen),
        .pos     (pos),
        .parity  (parity),
        .pdm_clk (pdm_clk_out)
    );

    for (genvar j = 0; j < N_RX; j++) begin : g_rx
        localparam int unsigned PEER = j ^ 1;
        logic        sel_din;
        pdm_sample_t l_s, r_s;

        assign sel_din = cfg_route_swap[j] ? pdm_data_in[PEER] : pdm_data_in[j];

        pdm_fe_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .ve      (ve),
            .hlen    (hlen),
            .pos     (pos),
            .parity  (parity),
            .halve   (cfg_halve),
            .dly     (cfg_sample_dly[j*DIV_W +: DIV_W]),
            .din     (sel_din),
            .left_o  (l_s),
            .right_o (r_s)
        );

        assign left_bit[j]  = l_s.data;
        assign left_vld[j]  = l_s.vld;
        assign right_bit[j] = r_s.data;
        assign right_vld[j] = r_s.vld;
    end
endmodule

// File: rtl/pdm_capture_frontend_chk.sv
module pdm_capture_frontend_chk
    import pdm_fe_pkg::*;
#(
    parameter int unsigned N_RX = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [DIV_W-1:0]      cfg_clk_div,
    input logic [N_RX-1:0]       cfg_route_swap,
    input logic [N_RX-1:0]       pdm_data_in,
    input logic                  pdm_clk_out,
    input logic [N_RX-1:0]       left_bit,
    input logic [N_RX-1:0]       left_vld,
    input logic [N_RX-1:0]       right_bit,
    input logic [N_RX-1:0]       right_vld
);
    span_t per_exp, hi_exp, hi_cnt, since_rise;
    logic  prev_clk, seen_rise;

    assign per_exp = span_t'(cfg_clk_div == '0 ? 1 : cfg_clk_div) + span_t'(1);
    assign hi_exp  = per_exp >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt     <= '0;
            since_rise <= '0;
            prev_clk   <= 1'b0;
            seen_rise  <= 1'b0;
        end else begin
            prev_clk <= pdm_clk_out;
            hi_cnt   <= pdm_clk_out ? hi_cnt + span_t'(1) : '0;
            if (pdm_clk_out && !prev_clk) begin
                since_rise <= span_t'(1);
                seen_rise  <= 1'b1;
            end else begin
                since_rise <= since_rise + span_t'(1);
            end
        end
    end

    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> (!pdm_clk_out && left_vld == '0 && right_vld == '0));

    p_period_r1: assert property (@(posedge clk) disable iff (rst)
        (pdm_clk_out && !prev_clk && seen_rise) |-> since_rise == per_exp);

    p_high_len_r2: assert property (@(posedge clk) disable iff (rst)
        (!pdm_clk_out && prev_clk) |-> hi_cnt == hi_exp);

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ((left_vld & $past(left_vld)) == '0) && ((right_vld & $past(right_vld)) == '0));

    for (genvar j = 0; j < N_RX; j++) begin : g_chk
        localparam int unsigned PEER = j ^ 1;
        p_route_left_r5: assert property (@(posedge clk) disable iff (rst)
            left_vld[j] |-> left_bit[j] ==
                (cfg_route_swap[j] ? $past(pdm_data_in[PEER]) : $past(pdm_data_in[j])));
        p_route_right_r5: assert property (@(posedge clk) disable iff (rst)
            right_vld[j] |-> right_bit[j] ==
                (cfg_route_swap[j] ? $past(pdm_data_in[PEER]) : $past(pdm_data_in[j])));
    end
endmodule

bind pdm_capture_frontend pdm_capture_frontend_chk #(.N_RX(N_RX)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_clk_div    (cfg_clk_div),
    .cfg_route_swap (cfg_route_swap),
    .pdm_data_in    (pdm_data_in),
    .pdm_clk_out    (pdm_clk_out),
    .left_bit       (left_bit),
    .left_vld       (left_vld),
    .right_bit      (right_bit),
    .right_vld      (right_vld)
);

// File: tb/pdm_capture_frontend_test.sv
`timescale 1ns/1ps
module pdm_capture_frontend_test;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     cfg_clk_div = 8'd3;
    logic [N*8-1:0] cfg_sample_dly;
    logic [N-1:0]   cfg_route_swap = '0;
    logic           cfg_halve = 1'b0;
    logic [N-1:0]   pdm_data_in = '0;
    logic           pdm_clk_out;
    logic [N-1:0]   left_bit, left_vld, right_bit, right_vld;

    int dly [N];
    int nchecks = 0;
    int nerrors = 0;
    bit done = 0;

    // reference model state
    int ve, p, nper;
    int exp_clk;
    int exp_lb [N], exp_lv [N], exp_rb [N], exp_rv [N];
    int prev_lv [N], prev_rv [N];

    always #2 clk = ~clk;

    always_comb
        for (int j = 0; j < N; j++) cfg_sample_dly[j*8 +: 8] = 8'(dly[j]);

    pdm_capture_frontend #(.N_RX(N)) uut (
        .clk(clk), .rst(rst), .cfg_clk_div(cfg_clk_div), .cfg_sample_dly(cfg_sample_dly),
        .cfg_route_swap(cfg_route_swap), .cfg_halve(cfg_halve), .pdm_data_in(pdm_data_in),
        .pdm_clk_out(pdm_clk_out), .left_bit(left_bit), .left_vld(left_vld),
        .right_bit(right_bit), .right_vld(right_vld)
    );

    function automatic bit period_ok(int n);
        return !cfg_halve || (n >= 0 && n % 2 == 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ve = (cfg_clk_div == 0) ? 1 : int'(cfg_clk_div);
            p = ve;
            nper = -1;
            exp_clk = 0;
            for (int j = 0; j < N; j++) begin
                exp_lb[j] = 0; exp_lv[j] = 0; exp_rb[j] = 0; exp_rv[j] = 0;
            end
        end else begin
            int per, hi, d, r, src;
            per = ve + 1;
            hi = per / 2;
            for (int j = 0; j < N; j++) begin
                d = (dly[j] > ve) ? ve : dly[j];
                src = int'(pdm_data_in[cfg_route_swap[j] ? (j ^ 1) : j]);
                exp_lv[j] = (p == d && period_ok(nper)) ? 1 : 0;
                if (exp_lv[j] == 1) exp_lb[j] = src;
                r = hi + d;
                if (r < per) exp_rv[j] = (p == r && period_ok(nper)) ? 1 : 0;
                else         exp_rv[j] = (p == r - per && period_ok(nper - 1)) ? 1 : 0;
                if (exp_rv[j] == 1) exp_rb[j] = src;
            end
            if (p == ve) begin p = 0; nper++; end
            else p++;
            exp_clk = (p < hi) ? 1 : 0;
        end
    end

    task automatic check(string req, string what, int act, int expv);
        nchecks++;
        if (act != expv) begin
            nerrors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic run_case(int div, int d0, int d1, int d2, int d3, logic [N-1:0] route,
                            logic halve, int cycles, string clk_tag, string vld_tag,
                            string rvld_tag, string bit_tag);
        @(negedge clk);
        rst = 1'b1;
        cfg_clk_div = 8'(div);
        dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
        cfg_route_swap = route;
        cfg_halve = halve;
        repeat (3) begin
            @(negedge clk);
            // R8: quiet outputs in reset
            check("R8", "reset clk", int'(pdm_clk_out), 0);
            check("R8", "reset vld", int'({left_vld, right_vld}), 0);
            check("R8", "reset bits", int'({left_bit, right_bit}), 0);
        end
        rst = 1'b0;
        for (int j = 0; j < N; j++) begin prev_lv[j] = 0; prev_rv[j] = 0; end
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check(clk_tag, "pdm_clk", int'(pdm_clk_out), exp_clk);
            for (int j = 0; j < N; j++) begin
                check(vld_tag, "left_vld", int'(left_vld[j]), exp_lv[j]);
                check(rvld_tag, "right_vld", int'(right_vld[j]), exp_rv[j]);
                if (exp_lv[j] == 1) check(bit_tag, "left_bit", int'(left_bit[j]), exp_lb[j]);
                if (exp_rv[j] == 1) check(bit_tag, "right_bit", int'(right_bit[j]), exp_rb[j]);
                // R9: strobes never two cycles in a row
                check("R9", "strobe width",
                      int'((left_vld[j] && prev_lv[j] == 1) || (right_vld[j] && prev_rv[j] == 1)), 0);
                prev_lv[j] = int'(left_vld[j]);
                prev_rv[j] = int'(right_vld[j]);
            end
            pdm_data_in = N'($urandom);
        end
    endtask

    initial begin
        for (int j = 0; j < N; j++) dly[j] = 0;
        run_case(3,   0, 1, 2, 3, 4'b0000, 1'b0, 60, "R1", "R3", "R4", "R5");
        run_case(4,   0, 2, 3, 1, 4'b0101, 1'b0, 60, "R2", "R3", "R4", "R5");
        run_case(0,   0, 1, 0, 5, 4'b1111, 1'b0, 40, "R1", "R3", "R4", "R5");
        run_case(5,   9, 200, 5, 2, 4'b0000, 1'b0, 60, "R2", "R7", "R7", "R5");
        run_case(3,   1, 0, 3, 2, 4'b1010, 1'b1, 80, "R1", "R6", "R6", "R5");
        run_case(7,   6, 7, 0, 3, 4'b0110, 1'b0, 70, "R2", "R3", "R4", "R5");
        run_case(7,   6, 2, 7, 5, 4'b0011, 1'b1, 90, "R2", "R6", "R6", "R5");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            nchecks++;
            nerrors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end
endmodule